// File: doc/BRIEF.md
# Battery-Tracking Gain Step Controller

This block sets the attenuation of an audio power amplifier from the battery voltage. A sampled battery reading in millivolts arrives every clock. It is compared against a trip level chosen by a three-way select input. When the battery sags to or below that level, the block works out a target gain that falls linearly with the shortfall. It then walks its attenuation code toward that target in 0.5 dB steps, quickly. When the battery recovers, it walks the code back toward nominal gain, slowly.

The output is a 5-bit code counting 0.5 dB steps below the nominal 20 dB (10 V/V) gain, from 0 to 20. The analog gain stage reads this code. The trip level is captured only when the block leaves reset and when the enable input rises, so a select pin that moves during playback has no effect. All timing windows are given in clock cycles by parameters: the first-step latency (QUAL_CYC), the attack interval (ATTACK_CYC) and the release interval (RELEASE_CYC).

Top module: `batt_gain_stepper`

## Requirements
- R1: The trip level is decoded from tripSel as 2'b00 = 3550 mV, 2'b01 = 3750 mV, and 2'b10 or 2'b11 = 3250 mV.
- R2: The trip level is captured on the first clock edge after reset release and on the edge at which enable is first seen high. tripSel changes at any other time have no effect on attenCode.
- R3: While vbattMv is above the latched trip level, no attenuation step is ever added.
- R4: The target gain is 10 - 30*(trip - vbatt)/5200 V/V. Attack steps continue while the gain of the current code, 20 - 0.5*code dB, is strictly above the target. For example, at a 3550 mV trip and a 3100 mV battery, the code settles at 6 (17.0 dB).
- R5: attenCode never exceeds 20, which is a 10 dB cut, even when the target gain is zero or negative.
- R6: A stretch of fewer than QUAL_CYC consecutive active edges at or below the trip level changes nothing. The first step lands on the QUAL_CYC-th such edge.
- R7: While the battery stays at or below the trip level, later attack steps land every ATTACK_CYC edges, for as long as R4 allows. A deeper sag raises the target.
- R8: With the battery above the trip level and attenCode nonzero, the code drops by one on the first edge that is at least RELEASE_CYC edges after the last code change. If that much time has already passed, the drop is immediate.
- R9: While the battery stays above the trip level, further release steps follow every RELEASE_CYC edges until the code reaches 0.
- R10: In reset, and on any edge where enable is low, attenCode becomes 0 and all timers clear. After enable rises, the first active edge is the one after the capture edge.
- R11: Apart from clearing, attenCode moves by at most one step per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on) |
| enable | input | 1 | Chip enable; low forces code 0 and clears timers |
| tripSel | input | 2 | Trip level select (encoding in R1) |
| vbattMv | input | VBATT_W | Battery voltage sample, unsigned millivolts |
| attenCode | output | 5 | Attenuation in 0.5 dB steps below 20 dB |

## Verification
Every result is registered once. A change in vbattMv that starts a run shows on attenCode after exactly QUAL_CYC edges, then after every ATTACK_CYC edges. A release shows RELEASE_CYC edges after the last change, or one edge after the battery recovers if that window has already elapsed. Enabling costs one capture edge before counting starts, and disabling clears the code on the next edge. The bench drives on falling edges and counts rising edges to one short of each due edge. It checks that the old code still holds, then advances one edge and checks the new code. Settled codes come from a real-valued model of the target formula.

// File: rtl/batt_gain_pkg.sv
package batt_gain_pkg;

  localparam int CODE_W   = 5;
  localparam int MAX_CODE = 20;
  localparam int GAIN_W   = 16;

  typedef struct packed {
    logic latchTrip;
    logic clearAll;
    logic stepAtten;
    logic stepRelease;
  } gainStrobe_t;

  // Linear gain of each attenuation step, V/V with 8 fractional bits:
  // round(256 * 10 ^ ((20 - 0.5*k) / 20)).
  function automatic logic [GAIN_W-1:0] stepThreshold(input int k);
    case (k)
      0:  return 16'd2560;
      1:  return 16'd2417;
      2:  return 16'd2282;
      3:  return 16'd2154;
      4:  return 16'd2033;
      5:  return 16'd1920;
      6:  return 16'd1812;
      7:  return 16'd1711;
      8:  return 16'd1615;
      9:  return 16'd1525;
      10: return 16'd1440;
      11: return 16'd1359;
      12: return 16'd1283;
      13: return 16'd1211;
      14: return 16'd1144;
      15: return 16'd1080;
      16: return 16'd1019;
      17: return 16'd962;
      18: return 16'd908;
      19: return 16'd858;
      default: return 16'd810;
    endcase
  endfunction

endpackage

// File: rtl/batt_gain_dp.sv
module batt_gain_dp
  import batt_gain_pkg::*;
#(
  parameter int VBATT_W       = 13,
  parameter int TRIP_GND_MV   = 3550,
  parameter int TRIP_VBAT_MV  = 3750,
  parameter int TRIP_FLOAT_MV = 3250,
  parameter int NOM_GAIN_Q    = 2560,
  parameter int SLOPE_NUM     = 7680,
  parameter int SLOPE_DEN     = 5200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         tripSel,
  input  logic [VBATT_W-1:0] vbattMv,
  input  gainStrobe_t        strobe,
  output logic               belowTrip,
  output logic               attackOk,
  output logic               releaseOk,
  output logic [CODE_W-1:0]  attenCode
);

  localparam int PROD_W = VBATT_W + GAIN_W;

  logic [VBATT_W-1:0] tripMv;
  logic [VBATT_W-1:0] tripDecoded;
  logic [VBATT_W-1:0] deficitMv;
  logic [PROD_W-1:0]  dropQ;
  logic [GAIN_W-1:0]  targetQ;
  logic [CODE_W-1:0]  attenQ;
  logic [GAIN_W-1:0]  thrTab [0:MAX_CODE];

  always_comb begin
    case (tripSel)
      2'b00:   tripDecoded = VBATT_W'(TRIP_GND_MV);
      2'b01:   tripDecoded = VBATT_W'(TRIP_VBAT_MV);
      default: tripDecoded = VBATT_W'(TRIP_FLOAT_MV);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tripMv <= VBATT_W'(TRIP_FLOAT_MV);
    else if (strobe.latchTrip) tripMv <= tripDecoded;
  end

  assign belowTrip = (vbattMv <= tripMv);
  assign deficitMv = belowTrip ? (tripMv - vbattMv) : '0;

  always_comb begin
    dropQ = (PROD_W'(deficitMv) * PROD_W'(SLOPE_NUM)) / PROD_W'(SLOPE_DEN);
    if (dropQ >= PROD_W'(NOM_GAIN_Q)) targetQ = '0;
    else                              targetQ = GAIN_W'(PROD_W'(NOM_GAIN_Q) - dropQ);
  end

  for (genvar k = 0; k <= MAX_CODE; k++) begin : g_thr
    assign thrTab[k] = stepThreshold(k);
  end

  assign attackOk  = belowTrip && (attenQ < CODE_W'(MAX_CODE)) && (thrTab[attenQ] > targetQ);
  assign releaseOk = !belowTrip && (attenQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    attenQ <= '0;
    else if (strobe.clearAll)     attenQ <= '0;
    else if (strobe.stepAtten)    attenQ <= attenQ + 1'b1;
    else if (strobe.stepRelease)  attenQ <= attenQ - 1'b1;
  end

  assign attenCode = attenQ;

  assert_code_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    attenQ <= CODE_W'(MAX_CODE));

  assert_single_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (attenQ != $past(attenQ) && !$past(strobe.clearAll)) |->
      (attenQ == $past(attenQ) + 1'b1 || attenQ == $past(attenQ) - 1'b1));

  assert_rise_needs_sag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (attenQ > $past(attenQ)) |-> $past(belowTrip));

  assert_fall_needs_recovery_R8: assert property (@(posedge clk) disable iff (!rstN)
    (attenQ < $past(attenQ) && !$past(strobe.clearAll)) |-> !$past(belowTrip));

  assert_trip_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.latchTrip) |-> $stable(tripMv));

endmodule

// File: rtl/batt_gain_ctl.sv
module batt_gain_ctl
  import batt_gain_pkg::*;
#(
  parameter int QUAL_CYC    = 4,
  parameter int ATTACK_CYC  = 10,
  parameter int RELEASE_CYC = 800000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        belowTrip,
  input  logic        attackOk,
  input  logic        releaseOk,
  output gainStrobe_t strobe
);

  localparam int LW = $clog2(QUAL_CYC + 1);
  localparam int AW = (ATTACK_CYC  > 1) ? $clog2(ATTACK_CYC)  : 1;
  localparam int RW = (RELEASE_CYC > 1) ? $clog2(RELEASE_CYC) : 1;

  logic          enableQ;
  logic          loadedQ;
  logic          active;
  logic [LW-1:0] lowRun;
  logic [AW-1:0] attackCnt;
  logic [RW-1:0] sinceChange;
  logic          attackTick;
  logic          releaseDue;

  assign active = enable && enableQ && loadedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      loadedQ <= 1'b0;
    end else begin
      enableQ <= enable;
      loadedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lowRun <= '0;
    else if (!active || !belowTrip)     lowRun <= '0;
    else if (lowRun != LW'(QUAL_CYC))   lowRun <= lowRun + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                                  attackCnt <= '0;
    else if (!active || !belowTrip || lowRun != LW'(QUAL_CYC))  attackCnt <= '0;
    else if (attackCnt == AW'(ATTACK_CYC - 1))                  attackCnt <= '0;
    else                                                        attackCnt <= attackCnt + 1'b1;
  end

  assign attackTick = active && belowTrip &&
                      ((lowRun == LW'(QUAL_CYC - 1)) ||
                       (lowRun == LW'(QUAL_CYC) && attackCnt == AW'(ATTACK_CYC - 1)));

  assign releaseDue = (sinceChange == RW'(RELEASE_CYC - 1));

  always_comb begin
    strobe.latchTrip   = !loadedQ || (enable && !enableQ);
    strobe.clearAll    = !active;
    strobe.stepAtten   = attackTick && attackOk;
    strobe.stepRelease = active && releaseOk && releaseDue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       sinceChange <= '0;
    else if (!active)                                sinceChange <= '0;
    else if (strobe.stepAtten || strobe.stepRelease) sinceChange <= '0;
    else if (!releaseDue)                            sinceChange <= sinceChange + 1'b1;
  end

  assert_steps_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.stepAtten && strobe.stepRelease));

  assert_no_step_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(strobe.stepAtten || strobe.stepRelease));

endmodule

// File: rtl/batt_gain_stepper.sv
module batt_gain_stepper
  import batt_gain_pkg::*;
#(
  parameter int VBATT_W       = 13,
  parameter int QUAL_CYC      = 4,
  parameter int ATTACK_CYC    = 10,
  parameter int RELEASE_CYC   = 800000,
  parameter int TRIP_GND_MV   = 3550,
  parameter int TRIP_VBAT_MV  = 3750,
  parameter int TRIP_FLOAT_MV = 3250
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         tripSel,
  input  logic [VBATT_W-1:0] vbattMv,
  output logic [4:0]         attenCode
);

  gainStrobe_t strobe;
  logic        belowTrip;
  logic        attackOk;
  logic        releaseOk;

  batt_gain_ctl #(
    .QUAL_CYC    (QUAL_CYC),
    .ATTACK_CYC  (ATTACK_CYC),
    .RELEASE_CYC (RELEASE_CYC)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .belowTrip (belowTrip),
    .attackOk  (attackOk),
    .releaseOk (releaseOk),
    .strobe    (strobe)
  );

  batt_gain_dp #(
    .VBATT_W       (VBATT_W),
    .TRIP_GND_MV   (TRIP_GND_MV),
    .TRIP_VBAT_MV  (TRIP_VBAT_MV),
    .TRIP_FLOAT_MV (TRIP_FLOAT_MV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tripSel   (tripSel),
    .vbattMv   (vbattMv),
    .strobe    (strobe),
    .belowTrip (belowTrip),
    .attackOk  (attackOk),
    .releaseOk (releaseOk),
    .attenCode (attenCode)
  );

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (attenCode == 5'd0));

endmodule

// File: tb/batt_gain_stepper_tb.sv
module batt_gain_stepper_tb;

  localparam int VW = 13;
  localparam int QC = 8;
  localparam int AC = 20;
  localparam int RC = 200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    tripSel = 2'b00;
  logic [VW-1:0] vbattMv = 13'd4000;
  logic [4:0]    attenCode;

  int checks = 0;
  int fails = 0;
  int jumpErrs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  batt_gain_stepper #(
    .VBATT_W(VW), .QUAL_CYC(QC), .ATTACK_CYC(AC), .RELEASE_CYC(RC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .tripSel(tripSel),
    .vbattMv(vbattMv), .attenCode(attenCode)
  );

  function automatic int tripOf(input logic [1:0] sel);
    if (sel == 2'b00) return 3550;
    if (sel == 2'b01) return 3750;
    return 3250;
  endfunction

  function automatic int expCode(input int tripMv, input int v);
    real g;
    real db;
    int n;
    if (v > tripMv) return 0;
    g = 10.0 - 30.0 * real'(tripMv - v) / 5200.0;
    if (g <= 0.0) return 20;
    db = 20.0 * $log10(g);
    n = 0;
    for (int k = 0; k < 20; k++) if (20.0 - 0.5 * real'(k) > db) n++;
    return n;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reEnable(input logic [1:0] sel, input int v);
    enable = 1'b0;
    tick(1);
    tripSel = sel;
    vbattMv = VW'(v);
    enable = 1'b1;
    tick(2);
  endtask

  // R11 monitor: outside of clearing, the code moves one step at most
  logic [4:0] prevCode = '0;
  logic prevEn = 1'b0;
  always @(negedge clk) begin
    if (rstN && enable && prevEn) begin
      if ((attenCode > prevCode + 5'd1) || (prevCode > attenCode + 5'd1)) jumpErrs++;
    end
    prevCode <= attenCode;
    prevEn <= enable;
  end

  task automatic testReset();
    tick(3);
    check("R10 reset code", attenCode, 0);
  endtask

  task automatic testPowerOnLatch();
    tripSel = 2'b10;
    enable = 1'b1;
    vbattMv = 13'd3400;
    rstN = 1'b1;
    tick(QC + 5 * AC);
    check("R1 floating trip 3250, battery 3400", attenCode, 0);
    tripSel = 2'b01;
    tick(QC + 5 * AC);
    check("R2 select change ignored while running", attenCode, 0);
    vbattMv = 13'd3000;
    tick(QC + 10 * AC);
    check("R2 power-on latched floating trip", attenCode, expCode(3250, 3000));
  endtask

  task automatic testAttackTiming();
    reEnable(2'b00, 3600);
    check("R10 cleared after re-enable", attenCode, 0);
    vbattMv = 13'd3100;
    tick(QC - 1);
    check("R6 no step before qualification", attenCode, 0);
    tick(1);
    check("R6 first step on qualifying edge", attenCode, 1);
    tick(AC - 1);
    check("R7 hold between attack steps", attenCode, 1);
    tick(1);
    check("R7 second attack step", attenCode, 2);
    tick(10 * AC);
    check("R4 settle at 3100 mV / 3550 trip", attenCode, expCode(3550, 3100));
    check("R4 settle value is 6", attenCode, 6);
  endtask

  task automatic testGlitch();
    reEnable(2'b00, 3600);
    vbattMv = 13'd3100;
    tick(QC - 1);
    vbattMv = 13'd3600;
    tick(2 * QC + AC);
    check("R6 short dip ignored", attenCode, 0);
    vbattMv = 13'd3100;
    tick(QC - 1);
    vbattMv = 13'd3600;
    tick(1);
    vbattMv = 13'd3100;
    tick(QC - 1);
    vbattMv = 13'd3600;
    tick(AC);
    check("R6 split dips do not add up", attenCode, 0);
  endtask

  task automatic testTargets();
    reEnable(2'b00, 3400);
    tick(QC + 25 * AC);
    check("R4 ground trip at 3400 mV", attenCode, expCode(tripOf(2'b00), 3400));
    vbattMv = 13'd3100;
    tick(25 * AC);
    check("R7 deeper sag raises target", attenCode, expCode(tripOf(2'b00), 3100));
    reEnable(2'b01, 3400);
    tick(QC + 25 * AC);
    check("R1 battery-tied trip at 3400 mV", attenCode, expCode(tripOf(2'b01), 3400));
    reEnable(2'b10, 3000);
    tick(QC + 25 * AC);
    check("R1 floating trip at 3000 mV", attenCode, expCode(tripOf(2'b10), 3000));
    reEnable(2'b11, 3400);
    tick(QC + 25 * AC);
    check("R3 code 11 decodes floating, above trip", attenCode, 0);
    reEnable(2'b00, 3550);
    tick(QC + 25 * AC);
    check("R3 battery equal to trip adds nothing", attenCode, 0);
  endtask

  task automatic testCap();
    reEnable(2'b00, 2000);
    tick(QC + 25 * AC);
    check("R5 deep sag capped at 20", attenCode, 20);
    vbattMv = 13'd0;
    tick(5 * AC);
    check("R5 zero battery still 20", attenCode, 20);
  endtask

  task automatic testDelayedRelease();
    reEnable(2'b00, 3700);
    vbattMv = 13'd3400;
    tick(QC);
    check("R6 step 1 before release test", attenCode, 1);
    tick(AC);
    check("R7 step 2 before release test", attenCode, 2);
    vbattMv = 13'd3700;
    tick(RC - 1);
    check("R8 release waits for window", attenCode, 2);
    tick(1);
    check("R8 release on window edge", attenCode, 1);
    tick(RC - 1);
    check("R9 hold between release steps", attenCode, 1);
    tick(1);
    check("R9 second release step", attenCode, 0);
    tick(2 * RC);
    check("R9 release stops at zero", attenCode, 0);
  endtask

  task automatic testImmediateRelease();
    reEnable(2'b00, 3700);
    vbattMv = 13'd3400;
    tick(QC + AC + RC + 10);
    check("R4 held at target before recovery", attenCode, 2);
    vbattMv = 13'd3700;
    tick(1);
    check("R8 immediate release after long hold", attenCode, 1);
    tick(RC - 1);
    check("R9 paced release hold", attenCode, 1);
    tick(1);
    check("R9 paced release step", attenCode, 0);
  endtask

  task automatic testEnableClear();
    reEnable(2'b00, 3400);
    tick(QC + 5 * AC);
    check("R4 code before disable", attenCode, 2);
    enable = 1'b0;
    tick(1);
    check("R10 disable clears code", attenCode, 0);
    tick(3);
    enable = 1'b1;
    tick(QC);
    check("R10 timers restart after enable", attenCode, 0);
    tick(1);
    check("R10 first step after capture edge", attenCode, 1);
    tripSel = 2'b01;
    reEnable(2'b01, 3600);
    tick(QC + 10 * AC);
    check("R2 enable rise recaptures trip", attenCode, expCode(3750, 3600));
  endtask

  initial begin
    testReset();
    testPowerOnLatch();
    testAttackTiming();
    testGlitch();
    testTargets();
    testCap();
    testDelayedRelease();
    testImmediateRelease();
    testEnableClear();
    check("R11 no multi-step jumps", jumpErrs, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule